// File: doc/BRIEF.md
# Keypad combination lock controller

A Moore state machine for the keypad of a door lock. It receives a clock edge only when a key is pressed. On each edge it sees either a programming strobe or a 3-bit letter code. From the idle state the user can do one of two things. Pressing the programming key and then three letters stores a new three-letter combination. Typing three letters straight away is an attempt to open the lock.

A correct attempt ends in the open state, which releases the latch. A wrong attempt ends in the failed state. Both outcomes are absorbing. Only the asynchronous reset, driven by an external inactivity watchdog, returns the machine to idle. That reset leaves the stored combination untouched.

Programming can be cancelled at any point by pressing the programming key again. The new combination is written only when the third letter arrives.

Top module: `keylock_ctrl`

## Requirements
- R1: While `wd_rst` is high, `state_code` is 0 (idle) and `release_latch` is 0. The reset does not change `combo_first`, `combo_second` or `combo_third`.
- R2: From power-up, before any programming, the combination reads 7, 0, 7.
- R3: In idle (0), a press with `set_press`=1 moves to state 4. The next three letter presses pass through state 5 and then state 7. The third letter returns the machine to 0, and only at that point are the three letters written, in order, to first, second and third.
- R4: A press with `set_press`=1 in state 4, 5 or 7 returns the machine to 0 and leaves the combination unchanged.
- R5: In idle, a letter press goes to state 1 and a second letter goes to state 2. The third letter goes to state 3 if the three letters equal first, second and third in that order. Otherwise it goes to state 6, whichever position mismatched.
- R6: A press with `set_press`=1 in state 1 or 2 leaves the state unchanged.
- R7: `release_latch` is 1 exactly when `state_code` is 3.
- R8: States 3 and 6 keep their state for every press, whether it is a letter or a programming strobe.
- R9: When `set_press` is 1, `letter_code` is ignored. The combination changes only on the third programming letter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| key_clk | input | 1 | One rising edge per key press |
| wd_rst | input | 1 | Asynchronous active-high reset from the inactivity watchdog |
| set_press | input | 1 | 1 when the pressed key is the programming key |
| letter_code | input | CODE_W | Letter code, from a=0 up to 7 |
| release_latch | output | 1 | 1 releases the door latch |
| state_code | output | 3 | Current state, 0 to 7 |
| combo_first | output | CODE_W | Stored first letter |
| combo_second | output | CODE_W | Stored second letter |
| combo_third | output | CODE_W | Stored third letter |

## Verification
The bench builds the block with its default parameters: a 3-bit letter code and a power-up combination of 7, 0, 7. That lets it reach the extreme codes 0 and 7, and a reprogrammed code whose first and last letters differ. The vectors send a mismatch at the first position and at the middle position. They cancel programming after one letter and after two, and press every key in both absorbing states. They also check that a reset arriving mid-sequence keeps a reprogrammed combination.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TRY1  = 3'd1,
    ST_TRY2  = 3'd2,
    ST_OPEN  = 3'd3,
    ST_PROG0 = 3'd4,
    ST_PROG1 = 3'd5,
    ST_FAIL  = 3'd6,
    ST_PROG2 = 3'd7
  } kl_state_e;

  function automatic logic in_prog(input kl_state_e st);
    return (st == ST_PROG0) || (st == ST_PROG1) || (st == ST_PROG2);
  endfunction

  function automatic logic in_try(input kl_state_e st);
    return (st == ST_TRY1) || (st == ST_TRY2);
  endfunction
endpackage

// File: rtl/keylock_match.sv
module keylock_match #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] letter,
  input  logic [CODE_W-1:0] wanted,
  output logic              hit
);
  function automatic logic code_eq(input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b);
    return ~|(a ^ b);
  endfunction

  assign hit = code_eq(letter, wanted);
endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
  import keylock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_in,
  input  logic      hit,
  output kl_state_e state,
  output logic      load_first,
  output logic      load_second,
  output logic      commit
);
  kl_state_e state_q, state_d;
  logic      miss_q, miss_d;

  always_comb begin
    state_d     = state_q;
    miss_d      = miss_q;
    load_first  = 1'b0;
    load_second = 1'b0;
    commit      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (set_in) state_d = ST_PROG0;
        else begin
          state_d = ST_TRY1;
          miss_d  = !hit;
        end
      end
      ST_TRY1: begin
        if (!set_in) begin
          state_d = ST_TRY2;
          miss_d  = miss_q | !hit;
        end
      end
      ST_TRY2: begin
        if (!set_in) state_d = (miss_q | !hit) ? ST_FAIL : ST_OPEN;
      end
      ST_PROG0: begin
        if (set_in) state_d = ST_IDLE;
        else begin
          state_d    = ST_PROG1;
          load_first = 1'b1;
        end
      end
      ST_PROG1: begin
        if (set_in) state_d = ST_IDLE;
        else begin
          state_d     = ST_PROG2;
          load_second = 1'b1;
        end
      end
      ST_PROG2: begin
        state_d = ST_IDLE;
        commit  = !set_in;
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= ST_IDLE;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
    end
  end

  assign state = state_q;

  p_cancel_r4: assert property (@(posedge clk) disable iff (rst)
    (in_prog(state_q) && set_in) |=> (state_q == ST_IDLE));

  p_set_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (in_try(state_q) && set_in) |=> $stable(state_q));

  p_absorb_r8: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_OPEN) || (state_q == ST_FAIL)) |=> $stable(state_q));

  p_early_miss_r5: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_TRY2) && miss_q && !set_in) |=> (state_q == ST_FAIL));
endmodule

// File: rtl/keylock_store.sv
module keylock_store #(
  parameter int                CODE_W = 3,
  parameter logic [CODE_W-1:0] INIT1  = CODE_W'(7),
  parameter logic [CODE_W-1:0] INIT2  = CODE_W'(0),
  parameter logic [CODE_W-1:0] INIT3  = CODE_W'(7)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_first,
  input  logic              load_second,
  input  logic              commit,
  input  logic [CODE_W-1:0] letter,
  output logic [CODE_W-1:0] c1,
  output logic [CODE_W-1:0] c2,
  output logic [CODE_W-1:0] c3
);
  logic [CODE_W-1:0] tmp1_q;
  logic [CODE_W-1:0] tmp2_q;
  logic [CODE_W-1:0] c1_q = INIT1;
  logic [CODE_W-1:0] c2_q = INIT2;
  logic [CODE_W-1:0] c3_q = INIT3;

  always_ff @(posedge clk) begin
    if (load_first)  tmp1_q <= letter;
    if (load_second) tmp2_q <= letter;
    if (commit) begin
      c1_q <= tmp1_q;
      c2_q <= tmp2_q;
      c3_q <= letter;
    end
  end

  assign c1 = c1_q;
  assign c2 = c2_q;
  assign c3 = c3_q;

  p_combo_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable({c1_q, c2_q, c3_q}));

  p_single_load_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({load_first, load_second, commit}) <= 1);
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int                CODE_W = 3,
  parameter logic [CODE_W-1:0] INIT1  = CODE_W'(7),
  parameter logic [CODE_W-1:0] INIT2  = CODE_W'(0),
  parameter logic [CODE_W-1:0] INIT3  = CODE_W'(7)
) (
  input  logic              key_clk,
  input  logic              wd_rst,
  input  logic              set_press,
  input  logic [CODE_W-1:0] letter_code,
  output logic              release_latch,
  output logic [2:0]        state_code,
  output logic [CODE_W-1:0] combo_first,
  output logic [CODE_W-1:0] combo_second,
  output logic [CODE_W-1:0] combo_third
);
  kl_state_e         state;
  logic              hit;
  logic              load_first;
  logic              load_second;
  logic              commit;
  logic [CODE_W-1:0] wanted;
  logic [CODE_W-1:0] c1, c2, c3;

  always_comb begin
    case (state)
      ST_TRY1: wanted = c2;
      ST_TRY2: wanted = c3;
      default: wanted = c1;
    endcase
  end

  keylock_match #(.CODE_W(CODE_W)) u_match (
    .letter (letter_code),
    .wanted (wanted),
    .hit    (hit)
  );

  keylock_fsm u_fsm (
    .clk         (key_clk),
    .rst         (wd_rst),
    .set_in      (set_press),
    .hit         (hit),
    .state       (state),
    .load_first  (load_first),
    .load_second (load_second),
    .commit      (commit)
  );

  keylock_store #(
    .CODE_W (CODE_W),
    .INIT1  (INIT1),
    .INIT2  (INIT2),
    .INIT3  (INIT3)
  ) u_store (
    .clk         (key_clk),
    .rst         (wd_rst),
    .load_first  (load_first),
    .load_second (load_second),
    .commit      (commit),
    .letter      (letter_code),
    .c1          (c1),
    .c2          (c2),
    .c3          (c3)
  );

  assign release_latch = (state == ST_OPEN);
  assign state_code    = state;
  assign combo_first   = c1;
  assign combo_second  = c2;
  assign combo_third   = c3;

  p_latch_hold_r7: assert property (@(posedge key_clk) disable iff (wd_rst)
    release_latch |=> release_latch);

  p_commit_idle_r3: assert property (@(posedge key_clk) disable iff (wd_rst)
    commit |=> (state_code == 3'd0));
endmodule

// File: tb/test_keylock_ctrl.sv
module test_keylock_ctrl;
  logic       key_clk = 1'b0;
  logic       wd_rst  = 1'b1;
  logic       set_press = 1'b0;
  logic [2:0] letter_code = 3'd0;
  logic       release_latch;
  logic [2:0] state_code;
  logic [2:0] combo_first, combo_second, combo_third;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  keylock_ctrl i_keylock_ctrl (
    .key_clk       (key_clk),
    .wd_rst        (wd_rst),
    .set_press     (set_press),
    .letter_code   (letter_code),
    .release_latch (release_latch),
    .state_code    (state_code),
    .combo_first   (combo_first),
    .combo_second  (combo_second),
    .combo_third   (combo_third)
  );

  // entry: {reset_op, set, letter, exp_state, exp_latch, exp_c1, exp_c2, exp_c3}
  localparam int NV = 36;
  localparam logic [17:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,3'd7,3'd1,1'b0,3'd7,3'd0,3'd7},  // R5 first letter
    {1'b0,1'b0,3'd0,3'd2,1'b0,3'd7,3'd0,3'd7},  // R5
    {1'b0,1'b0,3'd7,3'd3,1'b1,3'd7,3'd0,3'd7},  // R5 R7 open
    {1'b0,1'b1,3'd5,3'd3,1'b1,3'd7,3'd0,3'd7},  // R8 set in open
    {1'b0,1'b0,3'd3,3'd3,1'b1,3'd7,3'd0,3'd7},  // R8 letter in open
    {1'b1,1'b0,3'd0,3'd0,1'b0,3'd7,3'd0,3'd7},  // R1 reset
    {1'b0,1'b0,3'd7,3'd1,1'b0,3'd7,3'd0,3'd7},
    {1'b0,1'b1,3'd6,3'd1,1'b0,3'd7,3'd0,3'd7},  // R6
    {1'b0,1'b0,3'd1,3'd2,1'b0,3'd7,3'd0,3'd7},  // middle mismatch
    {1'b0,1'b0,3'd7,3'd6,1'b0,3'd7,3'd0,3'd7},  // R5 fail
    {1'b0,1'b0,3'd7,3'd6,1'b0,3'd7,3'd0,3'd7},  // R8
    {1'b0,1'b1,3'd7,3'd6,1'b0,3'd7,3'd0,3'd7},  // R8
    {1'b1,1'b0,3'd0,3'd0,1'b0,3'd7,3'd0,3'd7},  // R1
    {1'b0,1'b1,3'd7,3'd4,1'b0,3'd7,3'd0,3'd7},  // R3 R9
    {1'b0,1'b0,3'd1,3'd5,1'b0,3'd7,3'd0,3'd7},  // R3
    {1'b0,1'b0,3'd4,3'd7,1'b0,3'd7,3'd0,3'd7},  // R3
    {1'b0,1'b0,3'd4,3'd0,1'b0,3'd1,3'd4,3'd4},  // R3 commit
    {1'b1,1'b0,3'd0,3'd0,1'b0,3'd1,3'd4,3'd4},  // R1 keeps combo
    {1'b0,1'b1,3'd0,3'd4,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd2,3'd5,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b1,3'd7,3'd0,1'b0,3'd1,3'd4,3'd4},  // R4 cancel after one
    {1'b0,1'b1,3'd3,3'd4,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd5,3'd5,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd6,3'd7,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b1,3'd2,3'd0,1'b0,3'd1,3'd4,3'd4},  // R4 R9 cancel after two
    {1'b0,1'b0,3'd1,3'd1,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd4,3'd2,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd4,3'd3,1'b1,3'd1,3'd4,3'd4},  // R5 new code opens
    {1'b1,1'b0,3'd0,3'd0,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd0,3'd1,1'b0,3'd1,3'd4,3'd4},  // first mismatch
    {1'b0,1'b0,3'd4,3'd2,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd4,3'd6,1'b0,3'd1,3'd4,3'd4},  // R5
    {1'b1,1'b0,3'd0,3'd0,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd1,3'd1,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd0,3'd2,1'b0,3'd1,3'd4,3'd4},
    {1'b0,1'b0,3'd4,3'd6,1'b0,3'd1,3'd4,3'd4}   // R5 middle mismatch
  };

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual state/latch/combo=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] observed();
    return {state_code, release_latch, combo_first, combo_second, combo_third};
  endfunction

  task automatic press(input logic s, input logic [2:0] l);
    set_press   = s;
    letter_code = l;
    #1 key_clk = 1'b1;
    #1;
    key_clk = 1'b0;
    #1;
  endtask

  task automatic pulse_reset();
    wd_rst = 1'b1;
    #1 key_clk = 1'b1;
    #1 key_clk = 1'b0;
    #1 wd_rst = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    check("R2 power-up combination", {3'd0, 1'b0, combo_first, combo_second, combo_third},
          {3'd0, 1'b0, 3'd7, 3'd0, 3'd7});
    pulse_reset();
    check("R1 reset state", observed(), {3'd0, 1'b0, 3'd7, 3'd0, 3'd7});

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][17]) pulse_reset();
      else press(VEC[i][16], VEC[i][15:13]);
      check($sformatf("R3/R4/R5/R6/R7/R8/R9 vector %0d", i), observed(), VEC[i][12:0]);
    end

    // Directed: reset held high blocks presses (R1)
    wd_rst = 1'b1;
    press(1'b1, 3'd0);
    check("R1 held reset", observed(), {3'd0, 1'b0, 3'd1, 3'd4, 3'd4});
    wd_rst = 1'b0;
    #1;
    // Directed: reset in state 7 discards partial programming (R1 R3)
    press(1'b1, 3'd0);
    press(1'b0, 3'd2);
    press(1'b0, 3'd3);
    check("R3 partial programming", observed(), {3'd7, 1'b0, 3'd1, 3'd4, 3'd4});
    pulse_reset();
    check("R1 reset mid programming", observed(), {3'd0, 1'b0, 3'd1, 3'd4, 3'd4});
    // Directed: program 0,0,0 with set presses carrying nonzero letters ignored (R9)
    press(1'b1, 3'd7);
    press(1'b0, 3'd0);
    press(1'b0, 3'd0);
    press(1'b0, 3'd0);
    check("R9 program zeros", observed(), {3'd0, 1'b0, 3'd0, 3'd0, 3'd0});
    press(1'b0, 3'd0);
    press(1'b1, 3'd7);
    press(1'b0, 3'd0);
    press(1'b0, 3'd0);
    check("R7 open with zeros", observed(), {3'd3, 1'b1, 3'd0, 3'd0, 3'd0});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule